// File: doc/BRIEF.md
# Flash command sequence decoder

This block watches the bus write cycles aimed at a NOR-flash-style device and turns them into commands. Each write arrives as a one-cycle strobe with an address and a data word. The decoder tracks the unlock prefix (0xAA at 0x555, then 0x55 at 0x2AA) and the command byte that follows it. From these it produces registered start pulses for a program/erase engine and a read-source select that tells the read path whether to return array data, autoselect codes or operation status. The unlock and command addresses are compared on the low `UL_W` address bits only. The sector number is the top `SECT_W` address bits.

An unlock-bypass mode shortens programming. Once the mode is entered, a program needs only two writes instead of four, and it stays that way until the exit pair is written. A sector erase may name several sectors. Each 0x30 write that comes within a collection window adds one sector. The erase begins when `WIN_CYC` clock cycles pass with no further sector write. While the engine reports busy, command writes are ignored, except a suspend during an erase. A suspended erase is resumed by a single write. A one-cycle abort input returns the decoder to read-array at once.

States:
- ST_IDLE is read-array.
- ST_UL1 and ST_UL2 are the two prefix cycles.
- ST_PGM_DATA waits for the program address and data.
- ST_ERS_UL0, ST_ERS_UL1 and ST_ERS_UL2 are the second prefix of an erase.
- ST_SECT_WIN is the sector collection window.
- ST_AUTOSEL is the autoselect mode.
- ST_BYP, ST_BYP_PGM and ST_BYP_EXIT make up the bypass mode.

Transitions:
- ST_IDLE goes to ST_UL1 on the first unlock write.
- ST_UL1 goes to ST_UL2 on the second unlock write.
- From ST_UL2, a command at 0x555 selects the next state: 0xA0 goes to ST_PGM_DATA, 0x80 goes to ST_ERS_UL0, 0x90 goes to ST_AUTOSEL and 0x20 goes to ST_BYP.
- ST_PGM_DATA returns to ST_IDLE on the data write.
- ST_ERS_UL0, ST_ERS_UL1 and ST_ERS_UL2 advance through the second prefix.
- From ST_ERS_UL2, 0x10 at 0x555 starts a chip erase and returns to ST_IDLE. A 0x30 write at any address goes to ST_SECT_WIN.
- ST_SECT_WIN returns to ST_IDLE when the window expires (erase start) or on any write other than 0x30 (cancel).
- ST_AUTOSEL returns to ST_IDLE on 0xF0.
- ST_BYP goes to ST_BYP_PGM on 0xA0, and ST_BYP_PGM returns to ST_BYP on the data write.
- ST_BYP goes to ST_BYP_EXIT on 0x90. ST_BYP_EXIT goes to ST_IDLE on 0x00 and back to ST_BYP on anything else.
- A write that does not match the expected next cycle returns any prefix or erase state to ST_IDLE.
- Abort moves every state to ST_IDLE.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `rd_sel` is 2'b00 (array) and `bypass_on`, `suspended` and every pulse output are 0.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 and then data D at address A give `pgm_start` high for exactly the one cycle after the fourth write, with `pgm_addr`=A and `pgm_data`=D.
- R3: A write that breaks the unlock prefix or carries an unknown command returns the decoder to read-array. The writes that follow it produce no pulse until a complete fresh sequence is written.
- R4: The writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 give `ers_start`=1 with `ers_chip`=1 in the cycle after the sixth write.
- R5: With 0x30 at a sector address as the sixth write, `sect_add` pulses with `sect_id` equal to the top `SECT_W` address bits. Each further 0x30 write adds another sector. `ers_start` (with `ers_chip`=0) pulses exactly `WIN_CYC` cycles after the last sector write. Any other write during the window cancels the erase, and no `ers_start` follows.
- R6: The prefix followed by 0x90@0x555 sets `rd_sel` to 2'b01 (autoselect). Every write other than 0xF0, including full program sequences, leaves it there without any pulse. 0xF0 returns `rd_sel` to 2'b00.
- R7: The prefix followed by 0x20@0x555 sets `bypass_on`. In bypass, 0xA0 followed by one data write produces `pgm_start` with that write's address and data, and this can be repeated.
- R8: Bypass is left only by 0x90 followed by 0x00. A lone 0xF0, or 0x90 followed by another value, keeps `bypass_on` at 1. After the exit, a two-write program produces no `pgm_start`.
- R9: While `busy` is 1, `rd_sel` is 2'b10 (status) from the next cycle on. Writes other than a suspend are ignored, so an unlock prefix written while busy does not count toward a later program.
- R10: A 0xB0 write while `busy` is 1 and an erase is running gives `suspend_pulse` and sets `suspended`. A 0xB0 write while busy with a program does neither.
- R11: While suspended, an erase sequence starts no erase and a program sequence still works. A 0x30 write in read-array state gives `resume_pulse` and clears `suspended`.
- R12: A one-cycle `abort` returns the decoder to read-array in the next cycle. It clears autoselect, bypass and `suspended`, and it cancels an open sector window without an erase start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe | input | 1 | One-cycle pulse per bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; commands on bits 7:0 |
| busy | input | 1 | Program/erase engine running |
| abort | input | 1 | Reset-abort pulse |
| rd_sel | output | 2 | Read source: 00 array, 01 autoselect, 10 status |
| bypass_on | output | 1 | Unlock-bypass mode active |
| pgm_start | output | 1 | Program start pulse |
| pgm_addr | output | ADDR_W | Program address |
| pgm_data | output | DATA_W | Program data |
| ers_start | output | 1 | Erase start pulse |
| ers_chip | output | 1 | Erase kind: 1 whole device, 0 collected sectors |
| sect_add | output | 1 | Sector added to the erase list |
| sect_id | output | SECT_W | Sector number for `sect_add` |
| suspend_pulse | output | 1 | Erase suspend request |
| resume_pulse | output | 1 | Erase resume request |
| suspended | output | 1 | An erase is suspended |

## Verification
The hardest state to reach is a suspended erase with a further command arriving. It needs a complete six-write erase sequence, then `busy` raised as the engine would raise it, then a 0xB0 written while busy, and then `busy` dropped. The bench builds exactly that sequence before trying a blocked erase, an allowed program and the resume. The sector window is measured by counting clock cycles from the last sector write to `ers_start`, and its cancellation is shown by waiting well past the window.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int ADDR_UL1 = 32'h555;
    localparam int ADDR_UL2 = 32'h2AA;

    localparam logic [7:0] CODE_UL1   = 8'hAA;
    localparam logic [7:0] CODE_UL2   = 8'h55;
    localparam logic [7:0] CODE_PGM   = 8'hA0;
    localparam logic [7:0] CODE_ERASE = 8'h80;
    localparam logic [7:0] CODE_CHIP  = 8'h10;
    localparam logic [7:0] CODE_SECT  = 8'h30;
    localparam logic [7:0] CODE_AUTO  = 8'h90;
    localparam logic [7:0] CODE_BYP   = 8'h20;
    localparam logic [7:0] CODE_SUSP  = 8'hB0;
    localparam logic [7:0] CODE_RST   = 8'hF0;
    localparam logic [7:0] CODE_ZERO  = 8'h00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UL1,
        ST_UL2,
        ST_PGM_DATA,
        ST_ERS_UL0,
        ST_ERS_UL1,
        ST_ERS_UL2,
        ST_SECT_WIN,
        ST_AUTOSEL,
        ST_BYP,
        ST_BYP_PGM,
        ST_BYP_EXIT
    } fcd_state_t;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_PGM,
        CMD_ERASE,
        CMD_CHIP,
        CMD_SECT,
        CMD_AUTO,
        CMD_BYP,
        CMD_SUSP,
        CMD_RST,
        CMD_ZERO
    } fcd_cmd_t;

    typedef enum logic [1:0] {
        RD_ARRAY   = 2'b00,
        RD_AUTOSEL = 2'b01,
        RD_STATUS  = 2'b10
    } fcd_rd_t;

endpackage

// File: rtl/fcd_cycle_decode.sv
module fcd_cycle_decode
    import fcd_pkg::*;
#(
    parameter int UL_W = 11
) (
    input  logic [UL_W-1:0] addr_lo,
    input  logic [7:0]      data_lo,
    output logic            at_ul1,
    output logic            is_ul1,
    output logic            is_ul2,
    output fcd_cmd_t        cmd
);

    logic at_ul2;

    assign at_ul1 = (addr_lo == UL_W'(ADDR_UL1));
    assign at_ul2 = (addr_lo == UL_W'(ADDR_UL2));
    assign is_ul1 = at_ul1 && (data_lo == CODE_UL1);
    assign is_ul2 = at_ul2 && (data_lo == CODE_UL2);

    always_comb begin
        unique case (data_lo)
            CODE_PGM:   cmd = CMD_PGM;
            CODE_ERASE: cmd = CMD_ERASE;
            CODE_CHIP:  cmd = CMD_CHIP;
            CODE_SECT:  cmd = CMD_SECT;
            CODE_AUTO:  cmd = CMD_AUTO;
            CODE_BYP:   cmd = CMD_BYP;
            CODE_SUSP:  cmd = CMD_SUSP;
            CODE_RST:   cmd = CMD_RST;
            CODE_ZERO:  cmd = CMD_ZERO;
            default:    cmd = CMD_NONE;
        endcase
    end

endmodule

// File: rtl/fcd_win_timer.sv
module fcd_win_timer #(
    parameter int WIN_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);

    localparam int CNT_W = $clog2(WIN_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(WIN_CYC);
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run && (cnt_q == CNT_W'(1));

    // R5: the window count never exceeds its programmed length
    assert_win_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(WIN_CYC));

    // R5: an open window keeps counting down unless reloaded
    assert_win_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fcd_susp_track.sv
module fcd_susp_track (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic abort,
    input  logic ev_erase,
    input  logic ev_suspend,
    input  logic ev_resume,
    output logic erasing,
    output logic suspended
);

    logic busy_q;
    logic erasing_q;
    logic suspended_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            erasing_q   <= 1'b0;
            suspended_q <= 1'b0;
        end else begin
            busy_q <= busy;
            if (abort) begin
                erasing_q   <= 1'b0;
                suspended_q <= 1'b0;
            end else if (ev_suspend) begin
                erasing_q   <= 1'b0;
                suspended_q <= 1'b1;
            end else if (ev_resume) begin
                erasing_q   <= 1'b1;
                suspended_q <= 1'b0;
            end else if (ev_erase) begin
                erasing_q <= 1'b1;
            end else if (busy_q && !busy) begin
                erasing_q <= 1'b0;
            end
        end
    end

    assign erasing   = erasing_q;
    assign suspended = suspended_q;

    // R11: a suspended erase is never also counted as running
    assert_susp_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        suspended_q |-> !erasing_q);

endmodule

// File: rtl/fcd_fsm.sv
module fcd_fsm
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SECT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              abort,
    input  logic              at_ul1,
    input  logic              is_ul1,
    input  logic              is_ul2,
    input  fcd_cmd_t          cmd,
    input  logic              win_expire,
    input  logic              erasing,
    input  logic              suspended,
    output logic              win_load,
    output logic              win_run,
    output logic              ev_erase,
    output logic              ev_suspend,
    output logic              ev_resume,
    output fcd_rd_t           rd_sel,
    output logic              bypass_on,
    output logic              pgm_start,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              ers_start,
    output logic              ers_chip,
    output logic              sect_add,
    output logic [SECT_W-1:0] sect_id,
    output logic              suspend_pulse,
    output logic              resume_pulse
);

    fcd_state_t st_q, st_d;
    logic       wr_eff;
    logic       ev_pgm, ev_chip, ev_sect, ev_close;

    assign wr_eff = wr_strobe && !busy;

    always_comb begin
        st_d       = st_q;
        ev_pgm     = 1'b0;
        ev_chip    = 1'b0;
        ev_sect    = 1'b0;
        ev_close   = 1'b0;
        ev_suspend = 1'b0;
        ev_resume  = 1'b0;
        if (abort) begin
            st_d = ST_IDLE;
        end else begin
            if (wr_strobe && busy) begin
                ev_suspend = (cmd == CMD_SUSP) && erasing && !suspended;
            end
            if (wr_eff) begin
                unique case (st_q)
                    ST_IDLE: begin
                        if (is_ul1) begin
                            st_d = ST_UL1;
                        end else if (cmd == CMD_SECT && suspended) begin
                            ev_resume = 1'b1;
                        end
                    end
                    ST_UL1: st_d = is_ul2 ? ST_UL2 : ST_IDLE;
                    ST_UL2: begin
                        st_d = ST_IDLE;
                        if (at_ul1) begin
                            unique case (cmd)
                                CMD_PGM:   st_d = ST_PGM_DATA;
                                CMD_ERASE: st_d = suspended ? ST_IDLE : ST_ERS_UL0;
                                CMD_AUTO:  st_d = ST_AUTOSEL;
                                CMD_BYP:   st_d = ST_BYP;
                                default:   st_d = ST_IDLE;
                            endcase
                        end
                    end
                    ST_PGM_DATA: begin
                        ev_pgm = 1'b1;
                        st_d   = ST_IDLE;
                    end
                    ST_ERS_UL0: st_d = is_ul1 ? ST_ERS_UL1 : ST_IDLE;
                    ST_ERS_UL1: st_d = is_ul2 ? ST_ERS_UL2 : ST_IDLE;
                    ST_ERS_UL2: begin
                        if (at_ul1 && cmd == CMD_CHIP) begin
                            ev_chip = 1'b1;
                            st_d    = ST_IDLE;
                        end else if (cmd == CMD_SECT) begin
                            ev_sect = 1'b1;
                            st_d    = ST_SECT_WIN;
                        end else begin
                            st_d = ST_IDLE;
                        end
                    end
                    ST_SECT_WIN: begin
                        if (cmd == CMD_SECT) begin
                            ev_sect = 1'b1;
                        end else begin
                            st_d = ST_IDLE;
                        end
                    end
                    ST_AUTOSEL: begin
                        if (cmd == CMD_RST) begin
                            st_d = ST_IDLE;
                        end
                    end
                    ST_BYP: begin
                        if (cmd == CMD_PGM) begin
                            st_d = ST_BYP_PGM;
                        end else if (cmd == CMD_AUTO) begin
                            st_d = ST_BYP_EXIT;
                        end
                    end
                    ST_BYP_PGM: begin
                        ev_pgm = 1'b1;
                        st_d   = ST_BYP;
                    end
                    ST_BYP_EXIT: st_d = (cmd == CMD_ZERO) ? ST_IDLE : ST_BYP;
                    default: st_d = ST_IDLE;
                endcase
            end else if (st_q == ST_SECT_WIN && win_expire) begin
                ev_close = 1'b1;
                st_d     = ST_IDLE;
            end
        end
    end

    assign win_load = ev_sect;
    assign win_run  = (st_q == ST_SECT_WIN);
    assign ev_erase = ev_chip || ev_close;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_sel        <= RD_ARRAY;
            bypass_on     <= 1'b0;
            pgm_start     <= 1'b0;
            pgm_addr      <= '0;
            pgm_data      <= '0;
            ers_start     <= 1'b0;
            ers_chip      <= 1'b0;
            sect_add      <= 1'b0;
            sect_id       <= '0;
            suspend_pulse <= 1'b0;
            resume_pulse  <= 1'b0;
        end else begin
            if (busy) begin
                rd_sel <= RD_STATUS;
            end else if (st_d == ST_AUTOSEL) begin
                rd_sel <= RD_AUTOSEL;
            end else begin
                rd_sel <= RD_ARRAY;
            end
            bypass_on     <= (st_d == ST_BYP) || (st_d == ST_BYP_PGM) || (st_d == ST_BYP_EXIT);
            pgm_start     <= ev_pgm;
            ers_start     <= ev_erase;
            sect_add      <= ev_sect;
            suspend_pulse <= ev_suspend;
            resume_pulse  <= ev_resume;
            if (ev_pgm) begin
                pgm_addr <= wr_addr;
                pgm_data <= wr_data;
            end
            if (ev_erase) begin
                ers_chip <= ev_chip;
            end
            if (ev_sect) begin
                sect_id <= wr_addr[ADDR_W-1 -: SECT_W];
            end
        end
    end

    // R12: abort leaves read-array with no start pulse
    assert_abort_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (st_q == ST_IDLE && !pgm_start && !ers_start && !sect_add));

    // R9: a non-suspend write while busy does not move the state
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && busy && !abort && !(st_q == ST_SECT_WIN && win_expire)) |=> $stable(st_q));

    // R9: status is selected while the engine runs
    assert_status_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (rd_sel == RD_STATUS));

    // R10: a suspend request only follows a write seen while busy
    assert_susp_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_pulse |-> $past(busy && wr_strobe));

    // R7: in bypass the data write alone launches the program
    assert_byp_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_BYP_PGM && wr_strobe && !busy && !abort) |=> (pgm_start && bypass_on));

    // R2: program and erase starts never coincide
    assert_one_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_start, ers_start, sect_add, resume_pulse}));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int SECT_W  = 4,
    parameter int UL_W    = 11,
    parameter int WIN_CYC = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              abort,
    output logic [1:0]        rd_sel,
    output logic              bypass_on,
    output logic              pgm_start,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data,
    output logic              ers_start,
    output logic              ers_chip,
    output logic              sect_add,
    output logic [SECT_W-1:0] sect_id,
    output logic              suspend_pulse,
    output logic              resume_pulse,
    output logic              suspended
);

    logic     at_ul1, is_ul1, is_ul2;
    fcd_cmd_t cmd;
    logic     win_load, win_run, win_expire;
    logic     ev_erase, ev_suspend, ev_resume;
    logic     erasing;
    fcd_rd_t  rd_sel_e;

    fcd_cycle_decode #(.UL_W(UL_W)) u_dec (
        .addr_lo (wr_addr[UL_W-1:0]),
        .data_lo (wr_data[7:0]),
        .at_ul1  (at_ul1),
        .is_ul1  (is_ul1),
        .is_ul2  (is_ul2),
        .cmd     (cmd)
    );

    fcd_win_timer #(.WIN_CYC(WIN_CYC)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (win_load),
        .run    (win_run),
        .expire (win_expire)
    );

    fcd_susp_track u_susp (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .abort      (abort),
        .ev_erase   (ev_erase),
        .ev_suspend (ev_suspend),
        .ev_resume  (ev_resume),
        .erasing    (erasing),
        .suspended  (suspended)
    );

    fcd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_strobe     (wr_strobe),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .busy          (busy),
        .abort         (abort),
        .at_ul1        (at_ul1),
        .is_ul1        (is_ul1),
        .is_ul2        (is_ul2),
        .cmd           (cmd),
        .win_expire    (win_expire),
        .erasing       (erasing),
        .suspended     (suspended),
        .win_load      (win_load),
        .win_run       (win_run),
        .ev_erase      (ev_erase),
        .ev_suspend    (ev_suspend),
        .ev_resume     (ev_resume),
        .rd_sel        (rd_sel_e),
        .bypass_on     (bypass_on),
        .pgm_start     (pgm_start),
        .pgm_addr      (pgm_addr),
        .pgm_data      (pgm_data),
        .ers_start     (ers_start),
        .ers_chip      (ers_chip),
        .sect_add      (sect_add),
        .sect_id       (sect_id),
        .suspend_pulse (suspend_pulse),
        .resume_pulse  (resume_pulse)
    );

    assign rd_sel = rd_sel_e;

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int SECT_W  = 4;
    localparam int WIN_CYC = 50;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_strobe = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              busy = 1'b0;
    logic              abort = 1'b0;
    logic [1:0]        rd_sel;
    logic              bypass_on, pgm_start, ers_start, ers_chip, sect_add;
    logic [ADDR_W-1:0] pgm_addr;
    logic [DATA_W-1:0] pgm_data;
    logic [SECT_W-1:0] sect_id;
    logic              suspend_pulse, resume_pulse, suspended;

    int n_chk = 0;
    int n_fail = 0;
    int n_pgm = 0;
    int n_ers = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
                        .UL_W(11), .WIN_CYC(WIN_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .abort(abort), .rd_sel(rd_sel),
        .bypass_on(bypass_on), .pgm_start(pgm_start), .pgm_addr(pgm_addr),
        .pgm_data(pgm_data), .ers_start(ers_start), .ers_chip(ers_chip),
        .sect_add(sect_add), .sect_id(sect_id), .suspend_pulse(suspend_pulse),
        .resume_pulse(resume_pulse), .suspended(suspended)
    );

    always @(negedge clk) begin
        if (pgm_start) n_pgm <= n_pgm + 1;
        if (ers_start) n_ers <= n_ers + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_strobe = 1'b1;
        wr_addr   = a;
        wr_data   = d;
        @(negedge clk);
        wr_strobe = 1'b0;
    endtask

    task automatic unlock;
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h55);
    endtask

    task automatic erase_prefix;
        unlock();
        wr(16'h0555, 8'h80);
        unlock();
    endtask

    task automatic pulse_abort;
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rd_sel", 32'(rd_sel), 0);
        check("R1 bypass_on", 32'(bypass_on), 0);
        check("R1 suspended", 32'(suspended), 0);
        check("R1 pulses", 32'({pgm_start, ers_start, sect_add, suspend_pulse, resume_pulse}), 0);
    endtask

    task automatic t_program;
        unlock();
        wr(16'h0555, 8'hA0);
        wr(16'h1234, 8'h5C);
        check("R2 pgm_start", 32'(pgm_start), 1);
        check("R2 pgm_addr", 32'(pgm_addr), 32'h1234);
        check("R2 pgm_data", 32'(pgm_data), 32'h5C);
        idle(1);
        check("R2 pgm_start one cycle", 32'(pgm_start), 0);
        unlock();
        wr(16'h0555, 8'hA0);
        wr(16'hBEEF, 8'h03);
        check("R2 second pgm_addr", 32'(pgm_addr), 32'hBEEF);
        check("R2 second pgm_data", 32'(pgm_data), 32'h03);
    endtask

    task automatic t_mismatch;
        int base;
        idle(2);
        base = n_pgm;
        wr(16'h0555, 8'hAA);
        wr(16'h02AA, 8'h54);
        wr(16'h0555, 8'hA0);
        wr(16'h4444, 8'h11);
        unlock();
        wr(16'h0555, 8'h77);
        wr(16'h0555, 8'hA0);
        wr(16'h1111, 8'h22);
        idle(2);
        check("R3 no program after broken sequence", 32'(n_pgm - base), 0);
        unlock();
        wr(16'h0555, 8'hA0);
        wr(16'h0042, 8'h42);
        check("R3 recovery program", 32'(pgm_start), 1);
    endtask

    task automatic t_chip;
        erase_prefix();
        wr(16'h0555, 8'h10);
        check("R4 ers_start", 32'(ers_start), 1);
        check("R4 ers_chip", 32'(ers_chip), 1);
    endtask

    task automatic t_sector;
        int first;
        int cnt;
        int base;
        erase_prefix();
        wr(16'h3000, 8'h30);
        check("R5 sect_add first", 32'(sect_add), 1);
        check("R5 sect_id first", 32'(sect_id), 3);
        wr(16'hA123, 8'h30);
        check("R5 sect_add second", 32'(sect_add), 1);
        check("R5 sect_id second", 32'(sect_id), 32'hA);
        first = 0;
        cnt = 0;
        for (int k = 1; k <= WIN_CYC + 5; k++) begin
            @(negedge clk);
            if (ers_start) begin
                cnt++;
                if (first == 0) first = k;
                check("R5 sector ers_chip", 32'(ers_chip), 0);
            end
        end
        check("R5 window length", 32'(first), 32'(WIN_CYC));
        check("R5 single erase start", 32'(cnt), 1);
        base = n_ers;
        erase_prefix();
        wr(16'h5000, 8'h30);
        wr(16'h0000, 8'h77);
        idle(WIN_CYC + 5);
        check("R5 cancelled window", 32'(n_ers - base), 0);
    endtask

    task automatic t_autosel;
        int base;
        unlock();
        wr(16'h0555, 8'h90);
        check("R6 autoselect entry", 32'(rd_sel), 1);
        idle(1);
        base = n_pgm;
        unlock();
        wr(16'h0555, 8'hA0);
        wr(16'h0100, 8'h12);
        idle(2);
        check("R6 stays autoselect", 32'(rd_sel), 1);
        check("R6 no program in autoselect", 32'(n_pgm - base), 0);
        wr(16'h0000, 8'hF0);
        check("R6 exit to array", 32'(rd_sel), 0);
    endtask

    task automatic t_bypass;
        int base;
        unlock();
        wr(16'h0555, 8'h20);
        check("R7 bypass entry", 32'(bypass_on), 1);
        wr(16'h0000, 8'hA0);
        wr(16'h2222, 8'h33);
        check("R7 bypass program", 32'(pgm_start), 1);
        check("R7 bypass addr", 32'(pgm_addr), 32'h2222);
        wr(16'h0000, 8'hA0);
        wr(16'h7777, 8'h99);
        check("R7 repeated bypass program", 32'({pgm_start, pgm_data}), 32'h199);
        wr(16'h0000, 8'hF0);
        check("R8 F0 keeps bypass", 32'(bypass_on), 1);
        wr(16'h0000, 8'h90);
        wr(16'h0000, 8'h11);
        check("R8 bad exit keeps bypass", 32'(bypass_on), 1);
        wr(16'h0000, 8'h90);
        wr(16'h0000, 8'h00);
        check("R8 exit pair", 32'(bypass_on), 0);
        idle(2);
        base = n_pgm;
        wr(16'h0000, 8'hA0);
        wr(16'h2222, 8'h33);
        idle(2);
        check("R8 no two-write program after exit", 32'(n_pgm - base), 0);
    endtask

    task automatic t_busy;
        int base;
        @(negedge clk);
        busy = 1'b1;
        idle(1);
        check("R9 status select", 32'(rd_sel), 2);
        unlock();
        @(negedge clk);
        busy = 1'b0;
        idle(1);
        check("R9 array after busy", 32'(rd_sel), 0);
        base = n_pgm;
        wr(16'h0555, 8'hA0);
        wr(16'h0001, 8'h01);
        idle(2);
        check("R9 prefix ignored while busy", 32'(n_pgm - base), 0);
    endtask

    task automatic t_suspend;
        int base;
        unlock();
        wr(16'h0555, 8'hA0);
        wr(16'h0010, 8'h10);
        @(negedge clk);
        busy = 1'b1;
        wr(16'h0000, 8'hB0);
        check("R10 no suspend during program", 32'({suspend_pulse, suspended}), 0);
        @(negedge clk);
        busy = 1'b0;
        idle(2);
        erase_prefix();
        wr(16'h0555, 8'h10);
        @(negedge clk);
        busy = 1'b1;
        idle(2);
        wr(16'h0000, 8'hB0);
        check("R10 suspend pulse", 32'(suspend_pulse), 1);
        check("R10 suspended set", 32'(suspended), 1);
        @(negedge clk);
        busy = 1'b0;
        idle(2);
        base = n_ers;
        erase_prefix();
        wr(16'h0555, 8'h10);
        idle(2);
        check("R11 erase blocked while suspended", 32'(n_ers - base), 0);
        unlock();
        wr(16'h0555, 8'hA0);
        wr(16'h0ABC, 8'h5A);
        check("R11 program while suspended", 32'(pgm_start), 1);
        wr(16'h0000, 8'h30);
        check("R11 resume pulse", 32'(resume_pulse), 1);
        check("R11 suspended cleared", 32'(suspended), 0);
    endtask

    task automatic t_abort;
        int base;
        unlock();
        wr(16'h0555, 8'h90);
        pulse_abort();
        check("R12 abort leaves autoselect", 32'(rd_sel), 0);
        unlock();
        wr(16'h0555, 8'h20);
        pulse_abort();
        check("R12 abort leaves bypass", 32'(bypass_on), 0);
        erase_prefix();
        wr(16'h0555, 8'h10);
        @(negedge clk);
        busy = 1'b1;
        wr(16'h0000, 8'hB0);
        @(negedge clk);
        busy = 1'b0;
        check("R12 suspended before abort", 32'(suspended), 1);
        pulse_abort();
        check("R12 abort clears suspended", 32'(suspended), 0);
        idle(2);
        base = n_ers;
        erase_prefix();
        wr(16'h6000, 8'h30);
        pulse_abort();
        idle(WIN_CYC + 5);
        check("R12 abort cancels window", 32'(n_ers - base), 0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_program();
        t_mismatch();
        t_chip();
        t_sector();
        t_autosel();
        t_bypass();
        t_busy();
        t_suspend();
        t_abort();
        idle(4);
        finish_run();
    end

endmodule